// File: doc/BRIEF.md
# Parallel Port Side with Handshake Lines

This block is one side of a CPU-facing parallel I/O adapter. An 8-bit CPU reaches it through two register addresses: a data address and a control address. Behind the data address sit either the direction register or the output register, chosen by a control bit. Each of the eight pins is driven from the output register when its direction bit is 1 and read from the outside when it is 0. Two handshake lines come with the port. The first line is input only. The second line is either an input or an output. Each input line has its own edge-detected flag, and these flags feed a single active-high interrupt request.

The bus side is a plain register strobe and not a stream. A read or write happens in the cycle where `rd_en` or `wr_en` is high, and the block never stalls. So there is no valid/ready pair and no back-pressure: each access takes exactly one cycle. `rd_data` is combinational from the address and the current state. When the second line is an output, it can be driven as a level or as a strobe. The strobe is triggered by data reads, or by data writes when `STROBE_ON_WRITE` is set. It ends either by itself after one cycle or when the next active edge arrives on the first line.

Top module: `pia_port`

## Requirements
- R1: After reset the direction register, output register, control register and both flags are zero. `pin_oe`, `c2_oe` and `irq` are low, and a control read returns 0x00.
- R2: With control bit 2 at 0, the data address reads and writes the direction register. With bit 2 at 1, it reaches the output register. `pin_oe` equals the direction register and `pin_out` equals the output register.
- R3: A data read with bit 2 at 1 returns the output register bit for each pin whose direction bit is 1, and `pin_in` for each pin whose direction bit is 0.
- R4: A control read returns {line-1 flag, line-2 flag, control[5:0]}, with the flags in bits 7 and 6. A control write stores only bits 5..0, so written values of bits 7 and 6 have no effect.
- R5: The line-1 flag sets when the synchronised `c1_in` changes to the level selected by control bit 1 (1 = rising, 0 = falling). The flag becomes visible after the third rising clock edge following the input change. The opposite edge does not set the flag.
- R6: With control bit 5 at 0, line 2 is an input. Bit 4 selects its active edge (1 = rising), and the matching edge sets the line-2 flag (read in bit 6).
- R7: `irq` is high exactly when (line-1 flag and bit 0) or (line-2 flag and bit 3). Setting an enable bit while its flag is already set raises `irq` after that write.
- R8: A data read with bit 2 at 1 clears both flags. A data read with bit 2 at 0 leaves them unchanged. If a flag set and a clearing read fall in the same cycle, the flag ends up set.
- R9: With control bits 5..4 = 11, `c2_oe` is high and `c2_out` takes control bit 3 from the edge that writes the control register (0x3C drives high, 0x34 drives low).
- R10: With control bits 5..3 = 101 and bit 2 at 1, a data read drives `c2_out` low for exactly one cycle.
- R11: With control bits 5..3 = 100 and bit 2 at 1, a data read drives `c2_out` low. It stays low until the next active line-1 edge or the next control write, and either of these returns it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | 0 = data address, 1 = control address |
| rd_en | input | 1 | Read strobe for this cycle |
| wr_en | input | 1 | Write strobe for this cycle |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data (combinational) |
| pin_in | input | 8 | Pin levels from outside |
| pin_out | output | 8 | Pin drive values |
| pin_oe | output | 8 | Per-pin output enable |
| c1_in | input | 1 | Handshake line 1 (input) |
| c2_in | input | 1 | Handshake line 2 when used as input |
| c2_out | output | 1 | Handshake line 2 drive value |
| c2_oe | output | 1 | Handshake line 2 output enable |
| irq | output | 1 | Interrupt request, active high |

## Verification
The hardest case to reach from the ports is the same-cycle collision in R8. In that case the synchroniser delivers a line-1 edge on the very clock edge where a clearing data read is taken. The stimulus changes `c1_in` at a falling clock edge and counts exactly two rising edges. It then holds `rd_en` through the third rising edge, which is the one that sets the flag. Afterwards it reads the flag back through the control address. The strobe that waits for a line-1 edge (R11) is also covered: the bench holds it low for several idle cycles before releasing it with that edge.

// File: rtl/pia_pkg.sv
package pia_pkg;
  localparam int CTL_W = 6;
  localparam int HS_LINES = 2;

  typedef struct packed {
    logic c2_is_out;   // bit 5
    logic c2_b4;       // bit 4: edge (input) / level mode (output)
    logic c2_b3;       // bit 3: enable (input) / level or restore (output)
    logic out_sel;     // bit 2: data address reaches output register
    logic c1_rise;     // bit 1: line-1 active edge
    logic c1_en;       // bit 0: line-1 interrupt enable
  } ctl_t;
endpackage

// File: rtl/pia_sync_edge.sv
module pia_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic rise_sel,
  output logic hit
);
  logic [STAGES-1:0] sh;
  logic              prev;
  logic              lvl;

  assign lvl = sh[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh   <= '0;
      prev <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-2:0], din};
      prev <= lvl;
    end
  end

  assign hit = (lvl ^ prev) & (lvl == rise_sel);
endmodule

// File: rtl/pia_data_regs.sv
module pia_data_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_dir,
  input  logic          wr_out,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] pin_in,
  output logic [DW-1:0] dir_q,
  output logic [DW-1:0] out_q,
  output logic [DW-1:0] pin_view
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
    end else begin
      if (wr_dir) dir_q <= wdata;
      if (wr_out) out_q <= wdata;
    end
  end

  for (genvar i = 0; i < DW; i++) begin : g_mix
    assign pin_view[i] = dir_q[i] ? out_q[i] : pin_in[i];
  end
endmodule

// File: rtl/pia_c2_drive.sv
module pia_c2_drive (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [2:0] new_mode,
  input  logic [2:0] cur_mode,
  input  logic       strobe_go,
  input  logic       c1_hit,
  output logic       c2_out,
  output logic       c2_oe
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= 1'b1;
    end else if (ctl_wr) begin
      lvl_q <= (new_mode[2] & new_mode[1]) ? new_mode[0] : 1'b1;
    end else if (cur_mode[2] & ~cur_mode[1]) begin
      if (strobe_go)        lvl_q <= 1'b0;
      else if (cur_mode[0]) lvl_q <= 1'b1;
      else if (c1_hit)      lvl_q <= 1'b1;
    end
  end

  assign c2_out = lvl_q;
  assign c2_oe  = cur_mode[2];
endmodule

// File: rtl/pia_port.sv
module pia_port
  import pia_pkg::*;
#(
  parameter int DW              = 8,
  parameter int SYNC_STAGES     = 2,
  parameter bit STROBE_ON_WRITE = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_sel,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic [DW-1:0] pin_in,
  output logic [DW-1:0] pin_out,
  output logic [DW-1:0] pin_oe,
  input  logic          c1_in,
  input  logic          c2_in,
  output logic          c2_out,
  output logic          c2_oe,
  output logic          irq
);
  ctl_t          ctl_q;
  logic          flag_c1, flag_c2;
  logic [HS_LINES-1:0] hs_in, hs_rise, hit;
  logic          ctl_wr, data_wr, data_rd, clr_rd, strobe_go;
  logic [DW-1:0] dir_q, out_q, pin_view;

  assign ctl_wr  = wr_en & reg_sel;
  assign data_wr = wr_en & ~reg_sel;
  assign data_rd = rd_en & ~reg_sel;
  assign clr_rd  = data_rd & ctl_q.out_sel;

  assign hs_in   = {c2_in, c1_in};
  assign hs_rise = {ctl_q.c2_b4, ctl_q.c1_rise};

  for (genvar l = 0; l < HS_LINES; l++) begin : g_line
    pia_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(hs_in[l]),
      .rise_sel(hs_rise[l]), .hit(hit[l])
    );
  end

  if (STROBE_ON_WRITE) begin : g_strobe_wr
    assign strobe_go = data_wr & ctl_q.out_sel;
  end else begin : g_strobe_rd
    assign strobe_go = clr_rd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      flag_c1 <= 1'b0;
      flag_c2 <= 1'b0;
    end else begin
      if (ctl_wr) ctl_q <= ctl_t'(wr_data[CTL_W-1:0]);
      if (hit[0])      flag_c1 <= 1'b1;
      else if (clr_rd) flag_c1 <= 1'b0;
      if (ctl_q.c2_is_out)  flag_c2 <= 1'b0;
      else if (hit[1])      flag_c2 <= 1'b1;
      else if (clr_rd)      flag_c2 <= 1'b0;
    end
  end

  pia_data_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_dir(data_wr & ~ctl_q.out_sel),
    .wr_out(data_wr &  ctl_q.out_sel),
    .wdata(wr_data), .pin_in(pin_in),
    .dir_q(dir_q), .out_q(out_q), .pin_view(pin_view)
  );

  pia_c2_drive u_c2 (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr),
    .new_mode(wr_data[5:3]),
    .cur_mode({ctl_q.c2_is_out, ctl_q.c2_b4, ctl_q.c2_b3}),
    .strobe_go(strobe_go), .c1_hit(hit[0]),
    .c2_out(c2_out), .c2_oe(c2_oe)
  );

  always_comb begin
    if (reg_sel)            rd_data = DW'({flag_c1, flag_c2, ctl_q});
    else if (ctl_q.out_sel) rd_data = pin_view;
    else                    rd_data = dir_q;
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq = (flag_c1 & ctl_q.c1_en) | (flag_c2 & ctl_q.c2_b3);
endmodule

// File: rtl/pia_port_chk.sv
module pia_port_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_sel,
  input logic          rd_en,
  input logic          wr_en,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] pin_oe,
  input logic          c2_out,
  input logic          c2_oe,
  input logic          irq,
  input logic [5:0]    ctl_q,
  input logic          flag_c1,
  input logic          flag_c2,
  input logic [1:0]    hit,
  input logic          strobe_go
);
  p_ctl_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel) |=> (ctl_q == $past(wr_data[5:0])));

  p_dir_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !reg_sel && !ctl_q[2]) |=> (pin_oe == $past(wr_data)));

  p_c1_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] |=> flag_c1);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !reg_sel && ctl_q[2] && hit == 2'b00) |=> (!flag_c1 && !flag_c2));

  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_c1 && !flag_c2) |-> !irq);

  p_setres_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel && wr_data[5:4] == 2'b11) |=> (c2_oe && c2_out == $past(wr_data[3])));

  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[5:3] == 3'b101 && !c2_out && !strobe_go && !(wr_en && reg_sel)) |=> c2_out);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[5:3] == 3'b100 && !c2_out && !hit[0] && !(wr_en && reg_sel)) |=> !c2_out);
endmodule

bind pia_port pia_port_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .rd_en(rd_en), .wr_en(wr_en),
  .wr_data(wr_data), .pin_oe(pin_oe), .c2_out(c2_out), .c2_oe(c2_oe), .irq(irq),
  .ctl_q(ctl_q), .flag_c1(flag_c1), .flag_c2(flag_c2), .hit(hit),
  .strobe_go(strobe_go)
);

// File: tb/pia_port_tb.sv
module pia_port_tb;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_sel = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0, rd_data, pin_in = '0, pin_out, pin_oe;
  logic       c1_in = 1'b0, c2_in = 1'b0, c2_out, c2_oe, irq;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  pia_port u_dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .c1_in(c1_in), .c2_in(c2_in), .c2_out(c2_out),
    .c2_oe(c2_oe), .irq(irq)
  );

  typedef struct packed {
    logic [1:0] op;     // 0 write, 1 read and compare
    logic       sel;
    logic [7:0] data;
    logic [7:0] pins;
    logic [7:0] exp;
    logic [3:0] req;
  } row_t;

  localparam int NROW = 10;
  localparam row_t TBL [NROW] = '{
    '{2'd0, 1'b1, 8'h00, 8'h00, 8'h00, 4'd2},  // R2 select direction reg
    '{2'd0, 1'b0, 8'hF0, 8'h00, 8'h00, 4'd2},  // R2 direction = F0
    '{2'd1, 1'b0, 8'h00, 8'h00, 8'hF0, 4'd2},  // R2 read back direction
    '{2'd0, 1'b1, 8'hC4, 8'h00, 8'h00, 4'd4},  // R4 bits 7,6 dropped
    '{2'd1, 1'b1, 8'h00, 8'h00, 8'h04, 4'd4},  // R4 control read
    '{2'd0, 1'b0, 8'hA5, 8'h00, 8'h00, 4'd2},  // R2 output reg = A5
    '{2'd1, 1'b0, 8'h00, 8'h3C, 8'hAC, 4'd3},  // R3 mixed read
    '{2'd1, 1'b0, 8'h00, 8'hC3, 8'hA3, 4'd3},  // R3 mixed read
    '{2'd0, 1'b1, 8'h00, 8'h00, 8'h00, 4'd2},  // R2 back to direction
    '{2'd1, 1'b0, 8'h00, 8'h00, 8'hF0, 4'd2}   // R2 direction kept
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic sel, output logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; rd_en = 1'b1;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  logic [7:0] v;
  bit done = 1'b0;

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    check(irq == 1'b0 && pin_oe == 8'h00 && c2_oe == 1'b0, "R1 outputs", {irq, pin_oe, c2_oe}, 0);
    bus_rd(1'b1, v);
    check(v == 8'h00, "R1 control", v, 8'h00);
    bus_rd(1'b0, v);
    check(v == 8'h00, "R1 direction", v, 8'h00);

    // table walk: R2 R3 R4
    for (int i = 0; i < NROW; i++) begin
      pin_in = TBL[i].pins;
      if (TBL[i].op == 2'd0) bus_wr(TBL[i].sel, TBL[i].data);
      else begin
        bus_rd(TBL[i].sel, v);
        check(v == TBL[i].exp, $sformatf("R%0d row %0d", TBL[i].req, i), v, TBL[i].exp);
      end
    end
    check(pin_oe == 8'hF0 && pin_out == 8'hA5, "R2 pins", {pin_oe, pin_out}, 16'hF0A5);

    // R5 rising edge, enabled
    bus_wr(1'b1, 8'h07);
    c1_in = 1'b1;
    tick(2);
    check(irq == 1'b0, "R5 not before third edge", irq, 0);
    tick(1);
    check(irq == 1'b1, "R5 flag on third edge", irq, 1);
    c1_in = 1'b0;
    tick(4);
    bus_rd(1'b1, v);
    check(v == 8'h87, "R5 flag held", v, 8'h87);
    // R8 clear by data read
    bus_rd(1'b0, v);
    bus_rd(1'b1, v);
    check(v == 8'h07 && irq == 1'b0, "R8 cleared", v, 8'h07);

    // R5 falling polarity: rising ignored
    bus_wr(1'b1, 8'h05);
    c1_in = 1'b1;
    tick(4);
    bus_rd(1'b1, v);
    check(v == 8'h05, "R5 opposite edge ignored", v, 8'h05);
    c1_in = 1'b0;
    tick(4);
    check(irq == 1'b1, "R5 falling edge", irq, 1);
    bus_rd(1'b0, v);

    // R7 late enable
    bus_wr(1'b1, 8'h04);
    c1_in = 1'b1; tick(4); c1_in = 1'b0; tick(4);
    check(irq == 1'b0, "R7 disabled", irq, 0);
    bus_wr(1'b1, 8'h01);
    check(irq == 1'b1, "R7 late enable", irq, 1);
    // R8 read in direction mode keeps flag
    bus_rd(1'b0, v);
    check(irq == 1'b1, "R8 direction read keeps flag", irq, 1);
    bus_wr(1'b1, 8'h05);
    bus_rd(1'b0, v);
    check(irq == 1'b0, "R8 output read clears", irq, 0);

    // R8 set and clear in same cycle
    bus_wr(1'b1, 8'h07);
    c1_in = 1'b1;
    tick(2);
    reg_sel = 1'b0; rd_en = 1'b1;
    tick(1);
    rd_en = 1'b0;
    bus_rd(1'b1, v);
    check(v == 8'h87, "R8 set wins", v, 8'h87);
    bus_rd(1'b0, v);

    // R6 line 2 input, rising, enabled
    bus_wr(1'b1, 8'h1C);
    c2_in = 1'b1;
    tick(4);
    bus_rd(1'b1, v);
    check(v == 8'h5C && irq == 1'b1, "R6 line-2 flag", v, 8'h5C);
    bus_rd(1'b0, v);
    c2_in = 1'b0;
    tick(4);
    check(irq == 1'b0, "R6 falling ignored", irq, 0);

    // R9 set/reset output
    bus_wr(1'b1, 8'h3C);
    check(c2_oe == 1'b1 && c2_out == 1'b1, "R9 drive high", {c2_oe, c2_out}, 2'b11);
    bus_wr(1'b1, 8'h34);
    check(c2_oe == 1'b1 && c2_out == 1'b0, "R9 drive low", {c2_oe, c2_out}, 2'b10);

    // R10 one-cycle strobe
    bus_wr(1'b1, 8'h2C);
    check(c2_out == 1'b1, "R10 rests high", c2_out, 1);
    bus_rd(1'b0, v);
    check(c2_out == 1'b0, "R10 strobe low", c2_out, 0);
    tick(1);
    check(c2_out == 1'b1, "R10 restored", c2_out, 1);

    // R11 strobe held until line-1 falling edge (c1_in is high now)
    bus_wr(1'b1, 8'h24);
    bus_rd(1'b0, v);
    tick(5);
    check(c2_out == 1'b0, "R11 held low", c2_out, 0);
    c1_in = 1'b0;
    tick(4);
    check(c2_out == 1'b1, "R11 released by edge", c2_out, 1);
    bus_rd(1'b0, v);
    check(c2_out == 1'b0, "R11 low again", c2_out, 0);
    bus_wr(1'b1, 8'h24);
    check(c2_out == 1'b1, "R11 control write restores", c2_out, 1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule